// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the counting and addressing core of a single DMA channel. Software programs a block length, a repeat count, a start source address and a control byte through a byte-wide register write port. Enabling the channel copies the programmed values into working counters. From then on, every accepted transfer strobe does three things: it moves the working source address up, down or not at all, it lowers the remaining transfer count, and on the final transfer of a block it reloads that count from the programmed length.

In repeat mode the working repeat count falls by one after each block, and the channel switches itself off once the count reaches zero. A programmed repeat count of zero makes the channel repeat without end. Without repeat mode the channel runs a single block and then switches itself off. A programmed block length of zero stands for the largest block the counter can hold. The memory bus master, the destination path, arbitration and trigger selection sit outside this block. A transfer is a single-cycle strobe that counts whenever the channel is enabled.

Top module: `dma_seq`

## Requirements
- R1: After reset, chanEn, srcAddr, xferLeft, repLeft, blockDone and chanDone are all zero. The programmed block length resets to 0x0100. The programmed repeat count and programmed address reset to zero.
- R2: Register indices are 0 (length low byte), 1 (length high byte), 2 (repeat count), 3 to 5 (address bytes, least significant first) and 6 (control). In the control byte, bit 0 is enable, bit 1 is repeat mode and bits 3:2 are direction. A control write with bit 0 set while the channel is disabled loads xferLeft, repLeft and srcAddr from the programmed values. A programmed length of zero loads as 0xFFFF.
- R3: Each transfer changes srcAddr according to the direction field: 01 adds one, 10 subtracts one, and 00 or 11 leave it unchanged. The address wraps modulo 2^24.
- R4: A cycle with xferStb high and chanEn high is a transfer and lowers xferLeft by one. A strobe while chanEn is low changes neither srcAddr nor xferLeft.
- R5: The transfer made when xferLeft is 1 raises blockDone for exactly the following cycle. In that same cycle xferLeft shows the programmed length reloaded, with zero reloading as 0xFFFF.
- R6: With repeat mode off, the channel switches itself off after its first block. chanEn drops and chanDone pulses high for one cycle, in the same cycle as blockDone.
- R7: With repeat mode on and a loaded repeat count N greater than zero, repLeft falls by one at the end of each block. The channel switches itself off, with a chanDone pulse, when the end of block N brings repLeft to zero.
- R8: With repeat mode on and a loaded repeat count of zero, blocks follow one another without end and repLeft stays at zero.
- R9: Writes to the length, repeat or address registers while the channel is enabled change only the programmed values. A new length takes effect at the next block reload. A new address or repeat count takes effect only at the next enable.
- R10: A control write with bit 0 clear switches the channel off in the following cycle without a chanDone pulse. srcAddr and xferLeft then hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regIdx | input | 3 | Register index for the write |
| regWdata | input | 8 | Write data byte |
| xferStb | input | 1 | One transfer takes place this cycle, if the channel is enabled |
| chanEn | output | 1 | Channel enabled |
| srcAddr | output | 24 | Working source address |
| xferLeft | output | 16 | Working count of transfers left in the block |
| repLeft | output | 8 | Working repeat count |
| blockDone | output | 1 | One-cycle pulse after the last transfer of a block |
| chanDone | output | 1 | One-cycle pulse when the channel switches itself off |

## Verification
The main function is driven by random programs: block lengths of one to four, repeat counts of zero to three, all four direction codes, random start addresses and strobe patterns with gaps. A cycle-accurate bench model checks every output on every cycle. Strobe gaps show that idle cycles hold the state. Short blocks put block ends back to back and show that the reload and the repeat decrement happen at the correct edge. A repeat count of zero shows that endless repetition differs from counted repetition. Directed cases cover address wrap in both directions, a zero length loading as 0xFFFF, writes made while the channel is running, and an explicit disable, each of which separates a correct design from a plausible wrong one.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  // direction codes for the source address step
  localparam logic [1:0] DIR_FIXED = 2'b00;
  localparam logic [1:0] DIR_UP    = 2'b01;
  localparam logic [1:0] DIR_DOWN  = 2'b10;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;    // copy programmed values into working state
    logic       step;    // one transfer happens this cycle
    logic       last;    // this transfer ends the block
    logic       decRep;  // lower the working repeat count
    logic [1:0] dir;     // address step direction
  } seqCmd_t;

endpackage

// File: rtl/dma_seq_dp.sv
module dma_seq_dp
  import dma_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REP_W = 8,
  parameter int ADDR_W = 24,
  parameter int IDX_W = 3,
  parameter logic [CNT_W-1:0] CNT_RST = 'h0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [7:0]        regWdata,
  input  seqCmd_t           cmd,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [CNT_W-1:0]  xferLeft,
  output logic [REP_W-1:0]  repLeft,
  output logic              cntIsLast,
  output logic              repIsZero,
  output logic              repIsOne
);

  localparam int CB = CNT_W / 8;
  localparam int RB = REP_W / 8;
  localparam int AB = ADDR_W / 8;
  localparam int REP_BASE = CB;
  localparam int ADDR_BASE = CB + RB;

  logic [CNT_W-1:0]  progCnt;
  logic [REP_W-1:0]  progRep;
  logic [ADDR_W-1:0] progAddr;

  logic [CNT_W-1:0]  workCnt;
  logic [REP_W-1:0]  workRep;
  logic [ADDR_W-1:0] workAddr;

  logic [CNT_W-1:0]  reloadVal;
  logic [ADDR_W-1:0] nextAddr;

  // programmed registers, byte writable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progCnt  <= CNT_RST;
      progRep  <= '0;
      progAddr <= '0;
    end else if (regWe) begin
      for (int b = 0; b < CB; b++)
        if (regIdx == IDX_W'(b)) progCnt[b*8 +: 8] <= regWdata;
      for (int b = 0; b < RB; b++)
        if (regIdx == IDX_W'(REP_BASE + b)) progRep[b*8 +: 8] <= regWdata;
      for (int b = 0; b < AB; b++)
        if (regIdx == IDX_W'(ADDR_BASE + b)) progAddr[b*8 +: 8] <= regWdata;
    end
  end

  // zero length stands for the full counter range
  assign reloadVal = (progCnt == '0) ? '1 : progCnt;

  always_comb begin
    unique case (cmd.dir)
      DIR_UP:   nextAddr = workAddr + 1'b1;
      DIR_DOWN: nextAddr = workAddr - 1'b1;
      default:  nextAddr = workAddr;
    endcase
  end

  // working state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workCnt  <= '0;
      workRep  <= '0;
      workAddr <= '0;
    end else if (cmd.load) begin
      workCnt  <= reloadVal;
      workRep  <= progRep;
      workAddr <= progAddr;
    end else if (cmd.step) begin
      workAddr <= nextAddr;
      workCnt  <= cmd.last ? reloadVal : workCnt - 1'b1;
      if (cmd.decRep) workRep <= workRep - 1'b1;
    end
  end

  assign srcAddr   = workAddr;
  assign xferLeft  = workCnt;
  assign repLeft   = workRep;
  assign cntIsLast = (workCnt == CNT_W'(1));
  assign repIsZero = (workRep == '0);
  assign repIsOne  = (workRep == REP_W'(1));

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int CTRL_IDX = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [IDX_W-1:0] regIdx,
  input  logic [3:0]       ctrlBits,
  input  logic             xferStb,
  input  logic             cntIsLast,
  input  logic             repIsZero,
  input  logic             repIsOne,
  output seqCmd_t          cmd,
  output logic             chanEn,
  output logic             blockDone,
  output logic             chanDone
);

  logic       enReg;
  logic       repMode;
  logic [1:0] dirReg;
  logic       ctrlWr;
  logic       start;
  logic       xfer;
  logic       lastXfer;
  logic       endChan;

  assign ctrlWr   = regWe && (regIdx == IDX_W'(CTRL_IDX));
  assign start    = ctrlWr && ctrlBits[0] && !enReg;
  assign xfer     = enReg && xferStb;
  assign lastXfer = xfer && cntIsLast;
  // counted repeat ends on the block that takes the count from one to zero
  assign endChan  = lastXfer && (!repMode || repIsOne);

  assign cmd.load   = start;
  assign cmd.step   = xfer;
  assign cmd.last   = lastXfer;
  assign cmd.decRep = lastXfer && repMode && !repIsZero;
  assign cmd.dir    = dirReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg     <= 1'b0;
      repMode   <= 1'b0;
      dirReg    <= DIR_FIXED;
      blockDone <= 1'b0;
      chanDone  <= 1'b0;
    end else begin
      if (ctrlWr) begin
        enReg   <= ctrlBits[0];
        repMode <= ctrlBits[1];
        dirReg  <= ctrlBits[3:2];
      end else if (endChan) begin
        enReg <= 1'b0;
      end
      blockDone <= lastXfer;
      chanDone  <= endChan && !ctrlWr;
    end
  end

  assign chanEn = enReg;

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REP_W = 8,
  parameter int ADDR_W = 24,
  parameter int IDX_W = 3,
  parameter logic [CNT_W-1:0] CNT_RST = 'h0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [7:0]        regWdata,
  input  logic              xferStb,
  output logic              chanEn,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [CNT_W-1:0]  xferLeft,
  output logic [REP_W-1:0]  repLeft,
  output logic              blockDone,
  output logic              chanDone
);

  localparam int CTRL_IDX = (CNT_W + REP_W + ADDR_W) / 8;

  seqCmd_t cmd;
  logic    cntIsLast;
  logic    repIsZero;
  logic    repIsOne;

  dma_seq_ctrl #(
    .IDX_W   (IDX_W),
    .CTRL_IDX(CTRL_IDX)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regIdx   (regIdx),
    .ctrlBits (regWdata[3:0]),
    .xferStb  (xferStb),
    .cntIsLast(cntIsLast),
    .repIsZero(repIsZero),
    .repIsOne (repIsOne),
    .cmd      (cmd),
    .chanEn   (chanEn),
    .blockDone(blockDone),
    .chanDone (chanDone)
  );

  dma_seq_dp #(
    .CNT_W  (CNT_W),
    .REP_W  (REP_W),
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .CNT_RST(CNT_RST)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regIdx   (regIdx),
    .regWdata (regWdata),
    .cmd      (cmd),
    .srcAddr  (srcAddr),
    .xferLeft (xferLeft),
    .repLeft  (repLeft),
    .cntIsLast(cntIsLast),
    .repIsZero(repIsZero),
    .repIsOne (repIsOne)
  );

endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
  parameter int CNT_W = 16,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              xferStb,
  input logic              chanEn,
  input logic [ADDR_W-1:0] srcAddr,
  input logic [CNT_W-1:0]  xferLeft,
  input logic              blockDone,
  input logic              chanDone
);

  // R4: a mid-block transfer lowers the count by one
  a_r4_count_down: assert property (@(posedge clk) disable iff (!rstN)
    (chanEn && xferStb && xferLeft != CNT_W'(1)) |=> (xferLeft == $past(xferLeft) - 1'b1));

  // R4: no strobe, no movement
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (chanEn && !xferStb) |=> ($stable(srcAddr) && $stable(xferLeft)));

  // R2: an enabled channel never holds a zero working count
  a_r2_count_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    chanEn |-> (xferLeft != '0));

  // R5: block end follows an accepted transfer
  a_r5_block_after_xfer: assert property (@(posedge clk) disable iff (!rstN)
    blockDone |-> $past(chanEn && xferStb));

  // R6: self switch-off comes with a block end and a cleared enable
  a_r6_done_with_block: assert property (@(posedge clk) disable iff (!rstN)
    chanDone |-> (blockDone && !chanEn));

endmodule

bind dma_seq dma_seq_chk #(
  .CNT_W (CNT_W),
  .ADDR_W(ADDR_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .xferStb  (xferStb),
  .chanEn   (chanEn),
  .srcAddr  (srcAddr),
  .xferLeft (xferLeft),
  .blockDone(blockDone),
  .chanDone (chanDone)
);

// File: tb/tb_dma_seq.sv
`timescale 1ns/1ps
module tb_dma_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regIdx = '0;
  logic [7:0]  regWdata = '0;
  logic        xferStb = 1'b0;
  logic        chanEn;
  logic [23:0] srcAddr;
  logic [15:0] xferLeft;
  logic [7:0]  repLeft;
  logic        blockDone;
  logic        chanDone;

  int total = 0;
  int bad = 0;

  // bench model of the requirements
  logic [15:0] pCnt = 16'h0100;
  logic [7:0]  pRep = '0;
  logic [23:0] pAddr = '0;
  logic        mEn = 0, mMode = 0;
  logic [1:0]  mDir = 0;
  logic [15:0] wCnt = 0;
  logic [7:0]  wRep = 0;
  logic [23:0] wAddr = 0;
  logic        mBD = 0, mCD = 0;

  always #2.5 clk = ~clk;

  dma_seq dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regIdx(regIdx), .regWdata(regWdata),
    .xferStb(xferStb), .chanEn(chanEn), .srcAddr(srcAddr), .xferLeft(xferLeft),
    .repLeft(repLeft), .blockDone(blockDone), .chanDone(chanDone)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rl(input logic [15:0] v);
    return (v == 16'h0) ? 16'hFFFF : v;
  endfunction

  task automatic modelStep(input logic we, input logic [2:0] idx, input logic [7:0] d,
                           input logic stb);
    logic endc;
    endc = 1'b0;
    mBD = 1'b0;
    if (mEn && stb) begin
      case (mDir)
        2'b01: wAddr = wAddr + 24'd1;
        2'b10: wAddr = wAddr - 24'd1;
        default: ;
      endcase
      if (wCnt == 16'd1) begin
        mBD = 1'b1;
        wCnt = rl(pCnt);
        if (mMode) begin
          if (wRep != 8'd0) begin
            wRep = wRep - 8'd1;
            if (wRep == 8'd0) endc = 1'b1;
          end
        end else begin
          endc = 1'b1;
        end
      end else begin
        wCnt = wCnt - 16'd1;
      end
    end
    mCD = endc && !(we && idx == 3'd6);
    if (we) begin
      case (idx)
        3'd0: pCnt[7:0] = d;
        3'd1: pCnt[15:8] = d;
        3'd2: pRep = d;
        3'd3: pAddr[7:0] = d;
        3'd4: pAddr[15:8] = d;
        3'd5: pAddr[23:16] = d;
        3'd6: begin
          if (d[0] && !mEn) begin
            wCnt = rl(pCnt);
            wRep = pRep;
            wAddr = pAddr;
          end
          mEn = d[0];
          mMode = d[1];
          mDir = d[3:2];
        end
        default: ;
      endcase
    end else if (endc) begin
      mEn = 1'b0;
    end
  endtask

  task automatic cyc(input logic we, input logic [2:0] idx, input logic [7:0] d,
                     input logic stb);
    @(negedge clk);
    regWe = we; regIdx = idx; regWdata = d; xferStb = stb;
    @(posedge clk);
    modelStep(we, idx, d, stb);
    #1;
    check("R3 srcAddr", srcAddr, wAddr);
    check("R4 xferLeft", xferLeft, wCnt);
    check("R7 repLeft", repLeft, wRep);
    check("R6 chanEn", chanEn, mEn);
    check("R5 blockDone", blockDone, mBD);
    check("R6 chanDone", chanDone, mCD);
  endtask

  task automatic wr(input logic [2:0] idx, input logic [7:0] d);
    cyc(1'b1, idx, d, 1'b0);
  endtask

  task automatic xf(input logic stb);
    cyc(1'b0, 3'd0, 8'd0, stb);
  endtask

  task automatic setAddr(input logic [23:0] a);
    wr(3'd3, a[7:0]); wr(3'd4, a[15:8]); wr(3'd5, a[23:16]);
  endtask

  task automatic setCnt(input logic [15:0] c);
    wr(3'd0, c[7:0]); wr(3'd1, c[15:8]);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog all requirements act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1 chanEn", chanEn, 0);
    check("R1 srcAddr", srcAddr, 0);
    check("R1 xferLeft", xferLeft, 0);
    check("R1 repLeft", repLeft, 0);
    check("R1 blockDone", blockDone, 0);
    check("R1 chanDone", chanDone, 0);

    // R1 default length seen at enable, R2 load
    wr(3'd6, 8'h01);
    check("R1 default length", xferLeft, 16'h0100);
    check("R1 default address", srcAddr, 0);
    xf(1'b1); xf(1'b1);
    check("R4 two transfers", xferLeft, 16'h00FE);
    // R10 disable mid-block
    wr(3'd6, 8'h00);
    check("R10 disabled", chanEn, 0);
    check("R10 no chanDone", chanDone, 0);
    xf(1'b1);
    check("R4 strobe ignored when off", xferLeft, 16'h00FE);
    check("R10 hold count", xferLeft, 16'h00FE);

    // R2 zero length
    setCnt(16'h0000);
    wr(3'd6, 8'h01);
    check("R2 zero length loads max", xferLeft, 16'hFFFF);
    wr(3'd6, 8'h00);

    // R3 wrap upward, R6 single block
    setCnt(16'd2); setAddr(24'hFFFFFF);
    wr(3'd6, 8'h05);
    xf(1'b1);
    check("R3 upward wrap", srcAddr, 24'h000000);
    xf(1'b1);
    check("R6 off after block", chanEn, 0);
    check("R6 chanDone", chanDone, 1);
    check("R5 reload", xferLeft, 16'd2);
    xf(1'b0);
    check("R5 pulse one cycle", blockDone, 0);

    // R3 wrap downward and code 11 fixed
    setAddr(24'h000000);
    wr(3'd6, 8'h09);
    xf(1'b1);
    check("R3 downward wrap", srcAddr, 24'hFFFFFF);
    xf(1'b1);
    setAddr(24'h123456);
    wr(3'd6, 8'h0D);
    xf(1'b1); xf(1'b1);
    check("R3 code 11 fixed", srcAddr, 24'h123456);

    // R8 endless repeat
    setCnt(16'd2); wr(3'd2, 8'd0);
    wr(3'd6, 8'h07);
    for (int i = 0; i < 12; i++) xf(1'b1);
    check("R8 still enabled", chanEn, 1);
    check("R8 repeat stays zero", repLeft, 0);
    wr(3'd6, 8'h00);

    // R7 counted repeat, R9 writes while running
    setCnt(16'd3); wr(3'd2, 8'd2); setAddr(24'h000100);
    wr(3'd6, 8'h07);
    check("R7 loaded repeat", repLeft, 2);
    xf(1'b1);
    setCnt(16'd5); setAddr(24'h00AAAA); wr(3'd2, 8'd9);
    check("R9 count untouched", xferLeft, 16'd2);
    check("R9 address untouched", srcAddr, 24'h000101);
    check("R9 repeat untouched", repLeft, 2);
    xf(1'b1); xf(1'b1);
    check("R9 new length at reload", xferLeft, 16'd5);
    check("R7 one block done", repLeft, 1);
    for (int i = 0; i < 5; i++) xf(1'b1);
    check("R7 off after last block", chanEn, 0);
    check("R7 chanDone", chanDone, 1);

    // random programs
    for (int s = 0; s < 40; s++) begin
      setCnt(16'(1 + ($urandom % 4)));
      wr(3'd2, 8'($urandom % 4));
      setAddr(24'($urandom));
      wr(3'd6, {4'h0, 2'($urandom), 1'($urandom), 1'b1});
      for (int i = 0; i < 40; i++) xf(($urandom % 3) != 0);
      wr(3'd6, 8'h00);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule